// File: doc/BRIEF.md
# I/O-Mapped Prescaled Down-Counter

This block is a 32-bit down-counting timer that the host reaches at one dword in its I/O space. Software picks that dword with a 16-bit placement register. Bits 15:2 of that register hold the base address, and bit 0 opens or closes the window. Once the window is open, an access whose address matches bits 15:2 reads the live count. A write loads new count bytes under byte-enable control.

The count runs on a slow time base. A second, unrelated clock is divided by eight in its own domain. Each completed division flips a toggle flag. The access domain resynchronises that flag and turns every change into a single-cycle decrement pulse, so each prescaled period removes exactly one from the count. The count stops at zero. A simple request/address/data strobe interface stands in for the host bus, and the placement register has its own write strobe.

Top module: `io_interval_timer`

## Requirements
- R1: The placement register resets to 0000h. Its bits 15:2 are the base address and bit 0 is the window enable, both written from `cfg_wdata`. Bit 1 always reads 0.
- R2: An access hits when `io_req` is high, the enable bit is 1, and `io_addr[15:2]` equals the base field. Address bits 1:0 play no part in the match. A hit raises `io_ack` in the same cycle.
- R3: A miss, or any access while the enable bit is 0, gives `io_ack` = 0 and `io_rdata` = 0, and a write on such an access leaves the count unchanged.
- R4: A read hit (`io_we` = 0) drives the current count onto `io_rdata` in the same cycle as `io_ack`. Outside read hits, `io_rdata` is 0.
- R5: A write hit loads byte k of `io_wdata` (bits 8k+7:8k) into count byte k where `io_be[k]` is 1. Bytes with `io_be[k]` = 0 keep their value.
- R6: The count drops by exactly one for every eight rising edges of `tick_clk` counted from the release of `tick_rst`, and by no more than one per access-clock cycle.
- R7: A count of zero stays zero on later ticks. It does not wrap.
- R8: After reset the full 32-bit count reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Access-domain clock |
| rst | input | 1 | Synchronous active-high reset, access domain |
| tick_clk | input | 1 | Time-base clock, asynchronous to clk |
| tick_rst | input | 1 | Synchronous active-high reset, time-base domain |
| cfg_we | input | 1 | Write strobe for the placement register |
| cfg_wdata | input | 16 | New placement value: base in 15:2, enable in 0 |
| cfg_rdata | output | 16 | Placement register read-back |
| io_req | input | 1 | I/O access request |
| io_we | input | 1 | 1 = write, 0 = read |
| io_addr | input | 16 | I/O address |
| io_be | input | 4 | Byte enables for writes |
| io_wdata | input | 32 | Write data |
| io_ack | output | 1 | Access hit the timer |
| io_rdata | output | 32 | Read data, zero unless a read hit |

## Verification
On every cycle the assertions check several rules. The reserved placement bit stays at zero. An acknowledge appears only with a request and an open window, and read data is zero outside an acknowledge. Without a load, the count never rises, never drops by more than one per cycle, and stays at zero once it reaches zero. The bench scenarios cover what those rules cannot show. They check the exact decode against the programmed base, the byte-lane merge on a load, that closed-window and missed writes leave the count untouched, and that exactly one decrement arrives per eight time-base edges across the clock crossing.

// File: rtl/iotmr_pkg.sv
package iotmr_pkg;

    localparam int ADDR_W  = 16;
    localparam int DATA_W  = 32;
    localparam int BE_W    = DATA_W / 8;
    localparam int BASE_LO = 2;

    typedef struct packed {
        logic [ADDR_W-1:BASE_LO] base;
        logic                    rsvd;
        logic                    en;
    } tmr_cfg_t;

    function automatic logic addr_match(input tmr_cfg_t cfg,
                                        input logic [ADDR_W-1:0] addr);
        return cfg.en && (addr[ADDR_W-1:BASE_LO] == cfg.base);
    endfunction

    function automatic logic [DATA_W-1:0] merge_bytes(input logic [DATA_W-1:0] old_v,
                                                      input logic [DATA_W-1:0] new_v,
                                                      input logic [BE_W-1:0]   be);
        logic [DATA_W-1:0] r;
        r = old_v;
        for (int k = 0; k < BE_W; k++) begin
            if (be[k]) r[8*k +: 8] = new_v[8*k +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/iotmr_prescaler.sv
module iotmr_prescaler #(
    parameter int DIV = 8
) (
    input  logic tick_clk,
    input  logic tick_rst,
    output logic tgl
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge tick_clk) begin
        if (tick_rst) begin
            cnt <= '0;
            tgl <= 1'b0;
        end else if (cnt == LAST) begin
            cnt <= '0;
            tgl <= ~tgl;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/iotmr_tick_sync.sv
module iotmr_tick_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tgl_in,
    output logic tick
);
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-1:0], tgl_in};
    end

    assign tick = sh[STAGES] ^ sh[STAGES-1];
endmodule

// File: rtl/iotmr_counter.sv
module iotmr_counter
    import iotmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [BE_W-1:0]   be,
    input  logic [DATA_W-1:0] wdata,
    input  logic              tick,
    output logic [DATA_W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (load) begin
            count <= merge_bytes(count, wdata, be);
        end else if (tick && (count != '0)) begin
            count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/io_interval_timer.sv
module io_interval_timer
    import iotmr_pkg::*;
#(
    parameter int DIV         = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_clk,
    input  logic              tick_rst,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic [ADDR_W-1:0] cfg_rdata,
    input  logic              io_req,
    input  logic              io_we,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [BE_W-1:0]   io_be,
    input  logic [DATA_W-1:0] io_wdata,
    output logic              io_ack,
    output logic [DATA_W-1:0] io_rdata
);
    tmr_cfg_t          cfg_q;
    logic              hit;
    logic              wr_load;
    logic              tgl;
    logic              tick;
    logic [DATA_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (cfg_we) begin
            cfg_q.base <= cfg_wdata[ADDR_W-1:BASE_LO];
            cfg_q.rsvd <= 1'b0;
            cfg_q.en   <= cfg_wdata[0];
        end
    end

    assign cfg_rdata = cfg_q;
    assign hit       = io_req && addr_match(cfg_q, io_addr);
    assign wr_load   = hit && io_we;
    assign io_ack    = hit;
    assign io_rdata  = (hit && !io_we) ? count_q : '0;

    iotmr_prescaler #(.DIV(DIV)) u_pre (
        .tick_clk (tick_clk),
        .tick_rst (tick_rst),
        .tgl      (tgl)
    );

    iotmr_tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .tgl_in (tgl),
        .tick   (tick)
    );

    iotmr_counter u_cnt (
        .clk   (clk),
        .rst   (rst),
        .load  (wr_load),
        .be    (io_be),
        .wdata (io_wdata),
        .tick  (tick),
        .count (count_q)
    );
endmodule

// File: rtl/iotmr_checker.sv
module iotmr_checker
    import iotmr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] cfg_rdata,
    input logic              io_req,
    input logic              io_ack,
    input logic [DATA_W-1:0] io_rdata,
    input logic              wr_load,
    input logic [DATA_W-1:0] count_q
);
    assert_rsvd_zero_R1: assert property (@(posedge clk) disable iff (rst)
        cfg_rdata[1] == 1'b0);

    assert_ack_needs_req_R2: assert property (@(posedge clk) disable iff (rst)
        io_ack |-> io_req);

    assert_ack_needs_enable_R3: assert property (@(posedge clk) disable iff (rst)
        io_ack |-> cfg_rdata[0]);

    assert_rdata_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        !io_ack |-> (io_rdata == '0));

    assert_no_rise_R6: assert property (@(posedge clk) disable iff (rst)
        !wr_load |=> (count_q <= $past(count_q)));

    assert_single_step_R6: assert property (@(posedge clk) disable iff (rst)
        (!wr_load && count_q != '0) |=> (count_q >= $past(count_q) - 1'b1));

    assert_hold_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (!wr_load && count_q == '0) |=> (count_q == '0));
endmodule

bind io_interval_timer iotmr_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_rdata (cfg_rdata),
    .io_req    (io_req),
    .io_ack    (io_ack),
    .io_rdata  (io_rdata),
    .wr_load   (wr_load),
    .count_q   (count_q)
);

// File: tb/io_interval_timer_test.sv
`timescale 1ns/1ps
module io_interval_timer_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        tick_clk = 1'b0;
    logic        tick_rst;
    logic        cfg_we;
    logic [15:0] cfg_wdata;
    logic [15:0] cfg_rdata;
    logic        io_req;
    logic        io_we;
    logic [15:0] io_addr;
    logic [3:0]  io_be;
    logic [31:0] io_wdata;
    logic        io_ack;
    logic [31:0] io_rdata;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    localparam logic [15:0] BASE = 16'h0300;

    always #2.5 clk = ~clk;

    io_interval_timer uut (
        .clk(clk), .rst(rst), .tick_clk(tick_clk), .tick_rst(tick_rst),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .io_req(io_req), .io_we(io_we), .io_addr(io_addr), .io_be(io_be),
        .io_wdata(io_wdata), .io_ack(io_ack), .io_rdata(io_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic pulse_tick(input int n);
        for (int i = 0; i < n; i++) begin
            #60 tick_clk = 1'b1;
            #60 tick_clk = 1'b0;
        end
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    task automatic write_cfg(input logic [15:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic do_io(input logic we, input logic [15:0] addr, input logic [3:0] be,
                         input logic [31:0] wd, output logic ack, output logic [31:0] rd);
        @(negedge clk);
        io_req = 1'b1; io_we = we; io_addr = addr; io_be = be; io_wdata = wd;
        #1;
        ack = io_ack; rd = io_rdata;
        @(negedge clk);
        io_req = 1'b0; io_we = 1'b0;
    endtask

    task automatic t_reset();
        logic a; logic [31:0] d;
        check("R1 reset placement", {16'h0, cfg_rdata}, 32'h0);
        do_io(1'b0, 16'h0000, 4'h0, 32'h0, a, d);
        check("R3 disabled at reset ack", {31'h0, a}, 32'h0);
        write_cfg(BASE | 16'h1);
        do_io(1'b0, BASE, 4'h0, 32'h0, a, d);
        check("R2 hit ack", {31'h0, a}, 32'h1);
        check("R8 reset count", d, 32'h0);
    endtask

    task automatic t_cfg();
        write_cfg(16'hFFFF);
        check("R1 reserved bit reads zero", {16'h0, cfg_rdata}, 32'h0000FFFD);
        write_cfg(BASE | 16'h1);
        check("R1 placement readback", {16'h0, cfg_rdata}, 32'h00000301);
    endtask

    task automatic t_load_read();
        logic a; logic [31:0] d;
        do_io(1'b1, BASE, 4'hF, 32'h12345678, a, d);
        check("R4 no read data on write", d, 32'h0);
        do_io(1'b0, BASE, 4'h0, 32'h0, a, d);
        check("R4 read ack", {31'h0, a}, 32'h1);
        check("R5 full load", d, 32'h12345678);
        do_io(1'b0, BASE | 16'h2, 4'h0, 32'h0, a, d);
        check("R2 low address bits ignored", d, 32'h12345678);
    endtask

    task automatic t_bytes();
        logic a; logic [31:0] d;
        do_io(1'b1, BASE, 4'b0010, 32'hFFFFAAFF, a, d);
        do_io(1'b0, BASE, 4'h0, 32'h0, a, d);
        check("R5 single byte lane", d, 32'h1234AA78);
        do_io(1'b1, BASE, 4'b1001, 32'hCC1111DD, a, d);
        do_io(1'b0, BASE, 4'h0, 32'h0, a, d);
        check("R5 outer byte lanes", d, 32'hCC34AADD);
    endtask

    task automatic t_miss();
        logic a; logic [31:0] d;
        do_io(1'b0, BASE + 16'h4, 4'h0, 32'h0, a, d);
        check("R3 miss ack", {31'h0, a}, 32'h0);
        check("R3 miss rdata", d, 32'h0);
        do_io(1'b1, BASE + 16'h4, 4'hF, 32'h0, a, d);
        do_io(1'b0, BASE, 4'h0, 32'h0, a, d);
        check("R3 miss write ignored", d, 32'hCC34AADD);
    endtask

    task automatic t_disabled();
        logic a; logic [31:0] d;
        write_cfg(BASE);
        do_io(1'b1, BASE, 4'hF, 32'h0, a, d);
        check("R3 disabled write ack", {31'h0, a}, 32'h0);
        do_io(1'b0, BASE, 4'h0, 32'h0, a, d);
        check("R3 disabled read rdata", d, 32'h0);
        write_cfg(BASE | 16'h1);
        do_io(1'b0, BASE, 4'h0, 32'h0, a, d);
        check("R3 disabled write ignored", d, 32'hCC34AADD);
    endtask

    task automatic t_count();
        logic a; logic [31:0] d;
        do_io(1'b1, BASE, 4'hF, 32'd100, a, d);
        pulse_tick(40);
        settle();
        do_io(1'b0, BASE, 4'h0, 32'h0, a, d);
        check("R6 five ticks", d, 32'd95);
        pulse_tick(4);
        settle();
        do_io(1'b0, BASE, 4'h0, 32'h0, a, d);
        check("R6 partial period", d, 32'd95);
        pulse_tick(4);
        settle();
        do_io(1'b0, BASE, 4'h0, 32'h0, a, d);
        check("R6 period complete", d, 32'd94);
    endtask

    task automatic t_sat();
        logic a; logic [31:0] d;
        do_io(1'b1, BASE, 4'hF, 32'd2, a, d);
        pulse_tick(40);
        settle();
        do_io(1'b0, BASE, 4'h0, 32'h0, a, d);
        check("R7 stops at zero", d, 32'd0);
        pulse_tick(8);
        settle();
        do_io(1'b0, BASE, 4'h0, 32'h0, a, d);
        check("R7 no wrap", d, 32'd0);
    endtask

    initial begin
        rst = 1'b1; tick_rst = 1'b1;
        cfg_we = 1'b0; cfg_wdata = '0;
        io_req = 1'b0; io_we = 1'b0; io_addr = '0; io_be = '0; io_wdata = '0;
        pulse_tick(2);
        repeat (4) @(negedge clk);
        rst = 1'b0; tick_rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_cfg();
        t_load_read();
        t_bytes();
        t_miss();
        t_disabled();
        t_count();
        t_sat();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule